// File: doc/BRIEF.md
# Tiled Multiply-Add Array

This block computes the unsigned value `x * y + k + m` for an X operand of `M_W` bits and a Y operand of `N_W` bits. The addend `k` is `M_W` bits wide and the addend `m` is `N_W` bits wide. The result is a single `M_W + N_W` bit word. It has no clock, no reset and no registers: the result follows the operands combinationally.

The array is built only from identical tiles. Each tile multiplies two 2-bit digits and adds two more operands in the same pass. The tiles are wired straight to each other, with no adder or gate between them.

Each tile produces:
- a 3-bit low sum,
- a top bit of weight 8,
- a spare carry of weight 4.

That spare carry does not depend on the tile's weight-4 addend input. Inside the array every tile feeds its spare carry back into that input, which makes the tile an exact 4-bit multiply-add. Each row of tiles takes one Y digit and passes its carry digit from tile to tile. The next row takes the upper digits of the row's result as its partial-sum addend.

Top module: `mac_array`

## Requirements
- R1: `s_o` equals `x_i * y_i + k_i + m_i`, computed as unsigned integers over the full `M_W + N_W` bits, for every input combination.
- R2: The result never needs more than `M_W + N_W` bits. With all four operands at their maximum value, `s_o` is all ones.
- R3: The block is purely combinational. A change on any input shows at `s_o` within the same clock period, with no clock or reset involved.
- R4: A tile whose weight-4 carry output drives its own weight-4 addend input gives {top, sum[2:0]} = a*b + K + Q, where `a`, `b`, `K` and `Q` are the tile's 2-bit operands. For a=2, b=3, K=1, Q=2 this is 9 (binary 1001).
- R5: A tile with a free weight-4 addend input `w` satisfies 8*top + 4*sum[2] + 2*sum[1] + sum[0] + 4*carry = a*b + K + Q + 4*w.
- R6: A tile's weight-4 carry output does not change when only its weight-4 addend input changes.
- R7: `s_o[1:0]` equals (x_i[1:0]*y_i[1:0] + k_i[1:0] + m_i[1:0]) mod 4.
- R8: When `x_i` or `y_i` is zero, `s_o` equals `k_i + m_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | M_W | Unsigned multiplicand |
| y_i | input | N_W | Unsigned multiplier |
| k_i | input | M_W | Unsigned addend, enters the first row as its partial sum |
| m_i | input | N_W | Unsigned addend, one 2-bit digit per row as that row's carry-in |
| s_o | output | M_W + N_W | Product plus both addends |

## Verification
The bound checkers test these on every input change:
- the exact array sum and the absence of overflow (R1, R2),
- the low result digit (R7),
- the zero-operand case (R8),
- the weighted tile identity (R5).

Some behaviour is visible only through the bench's stimulus:
- that the spare carry ignores the weight-4 input (R6), which needs the same operands applied twice with only that input changed;
- the self-fed tile example (R4);
- the same-period response (R3).

The bench runs every operand combination at 4x4, every tile combination, and constrained random operands at 8x6 with the extreme values added.

// File: rtl/mac_pkg.sv
package mac_pkg;
   localparam int unsigned DIGIT_W = 2;
   typedef logic [DIGIT_W-1:0] digit_t;

   function automatic int unsigned digit_count(input int unsigned width);
      return width / DIGIT_W;
   endfunction

   function automatic bit width_ok(input int unsigned width);
      return (width >= DIGIT_W) && ((width % DIGIT_W) == 0);
   endfunction
endpackage

// File: rtl/mac_tile.sv
module mac_tile
   import mac_pkg::*;
(
   input  digit_t     a_i,
   input  digit_t     b_i,
   input  digit_t     ka_i,
   input  digit_t     qa_i,
   input  logic       qw4_i,
   output logic [2:0] sum_o,
   output logic       top_o,
   output logic       mid_o
);
   logic [3:0] lo_w;
   logic [3:0] w2_cnt;
   logic       w4_a;
   logic [1:0] hi_w;

   // terms of weight 2, counted separately before shifting
   always_comb begin
      w2_cnt = 4'(a_i[0] & b_i[1]) + 4'(a_i[1] & b_i[0]) + 4'(ka_i[1]) + 4'(qa_i[1]);
      lo_w   = 4'(a_i[0] & b_i[0]) + 4'(ka_i[0]) + 4'(qa_i[0]) + (w2_cnt << 1);
   end

   // lo_w[3:2] counts 0..2 units of weight 4: split into two single bits
   assign w4_a  = lo_w[2] | lo_w[3];
   assign mid_o = lo_w[3];

   assign hi_w  = 2'(a_i[1] & b_i[1]) + 2'(w4_a) + 2'(qw4_i);
   assign sum_o = {hi_w[0], lo_w[1:0]};
   assign top_o = hi_w[1];
endmodule

// File: rtl/mac_row.sv
module mac_row
   import mac_pkg::*;
#(
   parameter int unsigned ROW_W = 4,
   localparam int unsigned ND = ROW_W / DIGIT_W
) (
   input  logic [ROW_W-1:0] x_i,
   input  digit_t           yd_i,
   input  logic [ROW_W-1:0] part_i,
   input  digit_t           cin_i,
   output digit_t           low_o,
   output logic [ROW_W-1:0] part_o
);
   if (!width_ok(ROW_W)) begin : g_bad_w
      $error("mac_row: ROW_W must be even and at least 2");
   end

   digit_t chain [0:ND];
   digit_t lowd  [0:ND-1];

   assign chain[0] = cin_i;

   for (genvar i = 0; i < ND; i++) begin : g_tile
      logic [2:0] sm;
      logic       tp;
      logic       fb;
      mac_tile u_tile (
         .a_i   (x_i[DIGIT_W*i +: DIGIT_W]),
         .b_i   (yd_i),
         .ka_i  (part_i[DIGIT_W*i +: DIGIT_W]),
         .qa_i  (chain[i]),
         .qw4_i (fb),
         .sum_o (sm),
         .top_o (tp),
         .mid_o (fb)
      );
      assign lowd[i]    = sm[1:0];
      assign chain[i+1] = {tp, sm[2]};
   end

   assign low_o = lowd[0];

   for (genvar i = 1; i < ND; i++) begin : g_up
      assign part_o[DIGIT_W*(i-1) +: DIGIT_W] = lowd[i];
   end
   assign part_o[ROW_W-1 -: DIGIT_W] = chain[ND];
endmodule

// File: rtl/mac_array.sv
module mac_array
   import mac_pkg::*;
#(
   parameter int unsigned M_W = 4,
   parameter int unsigned N_W = 4,
   localparam int unsigned RES_W = M_W + N_W,
   localparam int unsigned NROW = N_W / DIGIT_W
) (
   input  logic [M_W-1:0]   x_i,
   input  logic [N_W-1:0]   y_i,
   input  logic [M_W-1:0]   k_i,
   input  logic [N_W-1:0]   m_i,
   output logic [RES_W-1:0] s_o
);
   if (!width_ok(M_W)) begin : g_bad_m
      $error("mac_array: M_W must be even and at least 2");
   end
   if (!width_ok(N_W)) begin : g_bad_n
      $error("mac_array: N_W must be even and at least 2");
   end

   logic [M_W-1:0] part [0:NROW];
   assign part[0] = k_i;

   for (genvar j = 0; j < NROW; j++) begin : g_row
      mac_row #(.ROW_W(M_W)) u_row (
         .x_i    (x_i),
         .yd_i   (y_i[DIGIT_W*j +: DIGIT_W]),
         .part_i (part[j]),
         .cin_i  (m_i[DIGIT_W*j +: DIGIT_W]),
         .low_o  (s_o[DIGIT_W*j +: DIGIT_W]),
         .part_o (part[j+1])
      );
   end

   assign s_o[RES_W-1:N_W] = part[NROW];
endmodule

// File: rtl/mac_array_chk.sv
module mac_array_chk #(
   parameter int unsigned M_W = 4,
   parameter int unsigned N_W = 4
) (
   input logic [M_W-1:0]     x_i,
   input logic [N_W-1:0]     y_i,
   input logic [M_W-1:0]     k_i,
   input logic [N_W-1:0]     m_i,
   input logic [M_W+N_W-1:0] s_i
);
   localparam int unsigned RW = M_W + N_W + 1;
   logic [RW-1:0] full;
   logic [3:0]    d0;
   logic [RW-1:0] addends;

   always_comb begin
      full    = RW'(x_i) * RW'(y_i) + RW'(k_i) + RW'(m_i);
      addends = RW'(k_i) + RW'(m_i);
      d0      = 4'(x_i[1:0]) * 4'(y_i[1:0]) + 4'(k_i[1:0]) + 4'(m_i[1:0]);
      p_exact_sum_r1: assert (s_i == full[RW-2:0])
         else $error("R1 sum mismatch");
      p_no_overflow_r2: assert (full[RW-1] == 1'b0)
         else $error("R2 overflow");
      p_low_digit_r7: assert (s_i[1:0] == d0[1:0])
         else $error("R7 low digit mismatch");
      if ((x_i == '0) || (y_i == '0)) begin
         p_zero_operand_r8: assert (RW'(s_i) == addends)
            else $error("R8 zero operand mismatch");
      end
   end
endmodule

module mac_tile_chk (
   input logic [1:0] a_i,
   input logic [1:0] b_i,
   input logic [1:0] ka_i,
   input logic [1:0] qa_i,
   input logic       qw4_i,
   input logic [2:0] sum_i,
   input logic       top_i,
   input logic       mid_i
);
   logic [4:0] lhs;
   logic [4:0] rhs;
   always_comb begin
      lhs = 5'({top_i, sum_i}) + 5'({mid_i, 2'b00});
      rhs = 5'(a_i) * 5'(b_i) + 5'(ka_i) + 5'(qa_i) + 5'({qw4_i, 2'b00});
      p_weighted_sum_r5: assert (lhs == rhs)
         else $error("R5 tile identity broken");
   end
endmodule

bind mac_array mac_array_chk #(.M_W(M_W), .N_W(N_W)) u_chk (
   .x_i(x_i), .y_i(y_i), .k_i(k_i), .m_i(m_i), .s_i(s_o)
);

bind mac_tile mac_tile_chk u_tchk (
   .a_i(a_i), .b_i(b_i), .ka_i(ka_i), .qa_i(qa_i), .qw4_i(qw4_i),
   .sum_i(sum_o), .top_i(top_o), .mid_i(mid_o)
);

// File: tb/mac_array_tb_top.sv
module mac_array_tb_top;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [3:0] x4, y4, k4, m4;
   logic [7:0] s4;
   mac_array #(.M_W(4), .N_W(4)) dut_i (
      .x_i(x4), .y_i(y4), .k_i(k4), .m_i(m4), .s_o(s4)
   );

   logic [7:0]  xw, kw;
   logic [5:0]  yw, mw;
   logic [13:0] sw;
   mac_array #(.M_W(8), .N_W(6)) dut_w_i (
      .x_i(xw), .y_i(yw), .k_i(kw), .m_i(mw), .s_o(sw)
   );

   logic [1:0] ta, tb, tk, tq;
   logic       tw;
   logic [2:0] tsum;
   logic       ttop, tmid;
   mac_tile cell_i (
      .a_i(ta), .b_i(tb), .ka_i(tk), .qa_i(tq), .qw4_i(tw),
      .sum_o(tsum), .top_o(ttop), .mid_o(tmid)
   );

   logic [2:0] fsum;
   logic       ftop, ffb;
   mac_tile cell_fb_i (
      .a_i(ta), .b_i(tb), .ka_i(tk), .qa_i(tq), .qw4_i(ffb),
      .sum_o(fsum), .top_o(ftop), .mid_o(ffb)
   );

   function automatic longint unsigned ref_mac(longint unsigned x, longint unsigned y,
                                               longint unsigned k, longint unsigned m);
      return x * y + k + m;
   endfunction

   task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   task automatic drive4(input int x, input int y, input int k, input int m);
      @(negedge clk);
      x4 = 4'(x); y4 = 4'(y); k4 = 4'(k); m4 = 4'(m);
      #1;
   endtask

   task automatic drivew(input longint unsigned x, input longint unsigned y,
                         input longint unsigned k, input longint unsigned m);
      @(negedge clk);
      xw = 8'(x); yw = 6'(y); kw = 8'(k); mw = 6'(m);
      #1;
      check("R1 8x6", longint'(sw), ref_mac(x, y, k, m));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      x4 = '0; y4 = '0; k4 = '0; m4 = '0;
      xw = '0; yw = '0; kw = '0; mw = '0;
      ta = '0; tb = '0; tk = '0; tq = '0; tw = 1'b0;
      void'($urandom(32'd20240611));
      #2;
      check("R8 all-zero inputs", longint'(s4), 0);

      // R4 worked example on the self-fed tile
      @(negedge clk);
      ta = 2'd2; tb = 2'd3; tk = 2'd1; tq = 2'd2; tw = 1'b0;
      #1;
      check("R4 example 2*3+1+2", longint'({ftop, fsum}), 9);

      // R4 R5 R6 exhaustive tile
      for (int v = 0; v < 256; v++) begin
         longint unsigned c0_lo;
         @(negedge clk);
         {ta, tb, tk, tq} = 8'(v);
         tw = 1'b0;
         #1;
         check("R4 self-fed tile", longint'({ftop, fsum}), ref_mac(ta, tb, tk, tq));
         check("R5 tile w=0", longint'({ttop, tsum}) + 4 * longint'(tmid),
               ref_mac(ta, tb, tk, tq));
         c0_lo = longint'(tmid);
         tw = 1'b1;
         #1;
         check("R5 tile w=1", longint'({ttop, tsum}) + 4 * longint'(tmid),
               ref_mac(ta, tb, tk, tq) + 4);
         check("R6 carry ignores w", longint'(tmid), c0_lo);
      end

      // R3 same-period response: no clock edge between drive and sample
      @(posedge clk);
      #1;
      x4 = 4'd7; y4 = 4'd9; k4 = 4'd3; m4 = 4'd5;
      #1;
      check("R3 immediate response", longint'(s4), 71);

      // R1 R7 R8 exhaustive 4x4
      for (int v = 0; v < 65536; v++) begin
         drive4(v & 15, (v >> 4) & 15, (v >> 8) & 15, (v >> 12) & 15);
         check("R1 4x4", longint'(s4), ref_mac(x4, y4, k4, m4));
         check("R7 low bits", longint'(s4[1:0]),
               ref_mac(x4[1:0], y4[1:0], k4[1:0], m4[1:0]) % 4);
         if (x4 == 0 || y4 == 0)
            check("R8 zero operand", longint'(s4), longint'(k4) + longint'(m4));
      end

      // R2 maxima
      drive4(15, 15, 15, 15);
      check("R2 4x4 all ones", longint'(s4), 255);
      drivew(255, 63, 255, 63);
      check("R2 8x6 all ones", longint'(sw), 16383);
      drivew(0, 63, 255, 63);
      check("R8 8x6 zero x", longint'(sw), 318);
      drivew(255, 0, 0, 63);
      check("R8 8x6 zero y", longint'(sw), 63);
      drivew(128, 32, 0, 0);

      // R1 constrained random 8x6, biased toward extreme values
      for (int n = 0; n < 3000; n++) begin
         longint unsigned rx, ry, rk, rm;
         rx = longint'($urandom & 8'hff);
         ry = longint'($urandom & 6'h3f);
         rk = longint'($urandom & 8'hff);
         rm = longint'($urandom & 6'h3f);
         if (($urandom % 8) == 0) rx = 255;
         if (($urandom % 8) == 0) ry = 63;
         drivew(rx, ry, rk, rm);
      end

      finish_run();
   end
endmodule